// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it takes an operation code and two operands, produces an 8-bit result combinationally and, when the enable strobe is high, updates an 8-bit status register on the rising clock edge. The register is laid out, from bit 7 down to bit 0, as I (interrupt enable), T (bit transfer), H (half carry), S (sign), V (overflow), N (negative), Z (zero) and C (carry).

Each operation class has its own set of flags. Add, subtract, compare and two's complement drive all five arithmetic flags and S. Logic operations, increment and decrement leave C and H alone. The one's complement and the shifts leave only H alone. Nibble swap touches no flag. Subtract-with-carry and compare-with-carry chain the zero flag so that multi-byte compares work. Two operation codes set or clear one chosen status bit. A condition output compares any selected status bit against a wanted polarity for branch decisions. A signed greater-or-equal test is bit 4 (S) clear. A signed less-than test is bit 4 set.

The `wr` output tells the surrounding datapath whether the result should be written back. It is low for the compares, the flag operations and unused codes. The register file and program counter sit outside.

Top module: `alu8_status`

## Requirements
- R1: While `rst_n` is low the status register is 0x00, and after release it stays 0x00 until an enabled operation changes it.
- R2: Op 0 (add) and op 1 (add with carry-in C) give result = a + b (+C). C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, N is result bit 7 and Z is result == 0.
- R3: Op 2 (subtract) and op 3 (subtract with borrow C) give result = a − b (−C). Ops 4 and 5 compute the same values but drive `wr` low. C is the borrow out of bit 7, H is the borrow out of bit 3, and V is signed overflow.
- R4: For ops 3 and 5 the new Z is 1 only when the result is zero and Z was already 1. For ops 2 and 4, Z is simply result == 0.
- R5: Ops 6 (AND), 7 (OR) and 8 (XOR) set Z and N from the result and clear V. C (bit 0) and H (bit 5) are held.
- R6: Op 11 (increment) and op 12 (decrement) set Z and N from the result. V is 1 only for an increment of 0x7F or a decrement of 0x80. C and H are held.
- R7: Op 9 gives 0xFF − a, forces C to 1, clears V and holds H. Op 10 gives 0x00 − a with the full subtract flag rules, so C = (a ≠ 0) and V = (a == 0x80).
- R8: Shifts and rotates work as follows. Op 13 shifts left and op 14 shifts right, both logical. Op 15 rotates left through C, moving C into bit 0 and bit 7 into C. Op 16 rotates right through C, moving C into bit 7 and bit 0 into C. Op 17 shifts right arithmetically and keeps bit 7. For all of them C takes the bit shifted out, V = N XOR C, and H is held.
- R9: Op 18 swaps the high and low nibbles of a and leaves the status register unchanged.
- R10: After any enabled op in 0..17, S (bit 4) equals N XOR V.
- R11: Op 19 sets and op 20 clears status bit `bit_sel`. No other status bit changes.
- R12: When `en` is low the status register holds its value, whatever the op.
- R13: `cond` is 1 exactly when status bit `bit_sel` equals `br_set`. With bit_sel = 4, br_set = 0 is signed greater-or-equal and br_set = 1 is signed less-than.
- R14: Ops 21..31 are no-ops. The result equals a, `wr` is low and no status bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the status register |
| en | input | 1 | Commit the flag update of the current op at the next edge |
| op | input | 5 | Operation code |
| a | input | 8 | First operand (destination value) |
| b | input | 8 | Second operand |
| bit_sel | input | 3 | Status bit for flag set/clear and for the condition output |
| br_set | input | 1 | Polarity that `cond` tests for |
| result | output | 8 | Combinational result |
| wr | output | 1 | Result should be written back |
| sreg | output | 8 | Status register I T H S V N Z C |
| cond | output | 1 | Selected status bit equals `br_set` |

## Verification
The hardest behaviour to reach from the ports is the chained zero flag. It only shows when a with-carry subtract or compare gives a zero result while the incoming Z is clear, which a single isolated operation never produces. The stimulus presets the status register through the flag set/clear codes before every vector, so each vector starts from a chosen Z and C. It then runs two-byte compares in sequence: one pair equal in both bytes, and one pair whose low-byte borrow ripples into an equal high byte.

// File: rtl/alu8_status.sv
module alu8_status #(
  parameter int DW  = 8,
  parameter int OPW = 5,
  parameter int SW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [OPW-1:0]         op,
  input  logic [DW-1:0]          a,
  input  logic [DW-1:0]          b,
  input  logic [$clog2(SW)-1:0]  bit_sel,
  input  logic                   br_set,
  output logic [DW-1:0]          result,
  output logic                   wr,
  output logic [SW-1:0]          sreg,
  output logic                   cond
);
  localparam int MB = DW - 1;
  localparam int HB = DW / 2 - 1;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  localparam logic [OPW-1:0] OP_ADD = 0, OP_ADC = 1, OP_SUB = 2, OP_SBC = 3, OP_CP = 4,
    OP_CPC = 5, OP_AND = 6, OP_OR = 7, OP_XOR = 8, OP_COM = 9, OP_NEG = 10, OP_INC = 11,
    OP_DEC = 12, OP_LSL = 13, OP_LSR = 14, OP_ROL = 15, OP_ROR = 16, OP_ASR = 17,
    OP_SWAP = 18, OP_BSET = 19, OP_BCLR = 20;

  localparam logic [SW-1:0] M_ARITH = SW'(8'h3F);
  localparam logic [SW-1:0] M_LOGIC = SW'(8'h1E);
  localparam logic [SW-1:0] M_SHIFT = SW'(8'h1F);

  logic          c, z, chain, cin_a, cin_s;
  logic [DW:0]   sum, dif;
  logic [DW-1:0] sx, sy, res;
  logic          fc, fh, fv, fz, fn, fs;
  logic [SW-1:0] mask, fvec, sreg_nxt;

  assign c     = sreg[FC];
  assign z     = sreg[FZ];
  assign chain = (op == OP_SBC) || (op == OP_CPC);
  assign cin_a = (op == OP_ADC) & c;
  assign cin_s = chain & c;
  assign sx    = (op == OP_NEG) ? '0 : a;
  assign sy    = (op == OP_NEG) ? a : b;
  assign sum   = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin_a};
  assign dif   = {1'b0, sx} - {1'b0, sy} - {{DW{1'b0}}, cin_s};

  always_comb begin
    res  = a;
    fc   = c;
    fh   = sreg[FH];
    fv   = sreg[FV];
    mask = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        res  = sum[DW-1:0];
        fc   = sum[DW];
        fh   = (a[HB] & b[HB]) | (b[HB] & ~res[HB]) | (~res[HB] & a[HB]);
        fv   = (a[MB] & b[MB] & ~res[MB]) | (~a[MB] & ~b[MB] & res[MB]);
        mask = M_ARITH;
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        res  = dif[DW-1:0];
        fc   = dif[DW];
        fh   = (~sx[HB] & sy[HB]) | (sy[HB] & res[HB]) | (res[HB] & ~sx[HB]);
        fv   = (sx[MB] & ~sy[MB] & ~res[MB]) | (~sx[MB] & sy[MB] & res[MB]);
        mask = M_ARITH;
      end
      OP_AND: begin res = a & b; fv = 1'b0; mask = M_LOGIC; end
      OP_OR:  begin res = a | b; fv = 1'b0; mask = M_LOGIC; end
      OP_XOR: begin res = a ^ b; fv = 1'b0; mask = M_LOGIC; end
      OP_COM: begin res = ~a; fc = 1'b1; fv = 1'b0; mask = M_SHIFT; end
      OP_INC: begin
        res  = a + DW'(1);
        fv   = (a == {1'b0, {MB{1'b1}}});
        mask = M_LOGIC;
      end
      OP_DEC: begin
        res  = a - DW'(1);
        fv   = (a == {1'b1, {MB{1'b0}}});
        mask = M_LOGIC;
      end
      OP_LSL: begin res = {a[MB-1:0], 1'b0}; fc = a[MB]; fv = res[MB] ^ fc; mask = M_SHIFT; end
      OP_LSR: begin res = {1'b0, a[MB:1]};   fc = a[0];  fv = res[MB] ^ fc; mask = M_SHIFT; end
      OP_ROL: begin res = {a[MB-1:0], c};    fc = a[MB]; fv = res[MB] ^ fc; mask = M_SHIFT; end
      OP_ROR: begin res = {c, a[MB:1]};      fc = a[0];  fv = res[MB] ^ fc; mask = M_SHIFT; end
      OP_ASR: begin res = {a[MB], a[MB:1]};  fc = a[0];  fv = res[MB] ^ fc; mask = M_SHIFT; end
      OP_SWAP: res = {a[HB:0], a[MB:HB+1]};
      default: ;
    endcase
    fz = (res == '0) & (~chain | z);
    fn = res[MB];
    fs = fn ^ fv;
  end

  assign fvec = {sreg[SW-1:FH+1], fh, fs, fv, fn, fz, fc};

  always_comb begin
    if (op == OP_BSET)      sreg_nxt = sreg | (SW'(1) << bit_sel);
    else if (op == OP_BCLR) sreg_nxt = sreg & ~(SW'(1) << bit_sel);
    else                    sreg_nxt = (sreg & ~mask) | (fvec & mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  sreg <= '0;
    else if (en) sreg <= sreg_nxt;
  end

  assign result = res;
  assign wr     = (op <= OP_SWAP) && (op != OP_CP) && (op != OP_CPC);
  assign cond   = (sreg[bit_sel] == br_set);
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [4:0] op,
  input logic [2:0] bit_sel,
  input logic [7:0] sreg
);
  localparam logic [4:0] K_SBC = 3, K_CPC = 5, K_AND = 6, K_OR = 7, K_XOR = 8, K_COM = 9,
    K_INC = 11, K_DEC = 12, K_ASR = 17, K_SWAP = 18, K_BSET = 19, K_BCLR = 20;

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> sreg == $past(sreg));

  a_r9_swap_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == K_SWAP |=> sreg == $past(sreg));

  a_r5_logic_holds_ch: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == K_AND || op == K_OR || op == K_XOR || op == K_INC || op == K_DEC)
    |=> sreg[0] == $past(sreg[0]) && sreg[5] == $past(sreg[5]));

  a_r10_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
    en && op <= K_ASR |=> sreg[4] == (sreg[2] ^ sreg[3]));

  a_r11_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == K_BSET || op == K_BCLR) |=> $countones(sreg ^ $past(sreg)) <= 1);

  a_r11_bset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == K_BSET |=> sreg[$past(bit_sel)]);

  a_r7_com_sets_c: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == K_COM |=> sreg[0]);

  a_r4_sticky_z: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == K_SBC || op == K_CPC) && !sreg[1] |=> !sreg[1]);
endmodule

bind alu8_status alu8_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op), .bit_sel(bit_sel), .sreg(sreg)
);

// File: tb/alu8_status_tb.sv
module alu8_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] a = 8'h00, b = 8'h00;
  logic [2:0] bit_sel = 3'd0;
  logic       br_set = 1'b0;
  logic [7:0] result, sreg;
  logic       wr, cond;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [4:0] ADD = 0, ADC = 1, SUB = 2, SBC = 3, CP = 4, CPC = 5, AND_ = 6,
    OR_ = 7, XOR_ = 8, COM = 9, NEG = 10, INC = 11, DEC = 12, LSL = 13, LSR = 14,
    ROL = 15, ROR = 16, ASR = 17, SWAP = 18, BSET = 19, BCLR = 20;

  always #10 clk = ~clk;

  alu8_status u_dut (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b),
    .bit_sel(bit_sel), .br_set(br_set), .result(result), .wr(wr), .sreg(sreg), .cond(cond));

  // op, a, b, status before, expected result, expected status after
  localparam int NV = 26;
  localparam logic [44:0] VEC [NV] = '{
    {ADD,  8'h3A, 8'h26, 8'h00, 8'h60, 8'h20},  // R2 half carry
    {ADD,  8'h7F, 8'h01, 8'h00, 8'h80, 8'h2C},  // R2 overflow
    {ADC,  8'hFF, 8'h00, 8'h01, 8'h00, 8'h23},  // R2 carry in
    {SUB,  8'h10, 8'h01, 8'hC0, 8'h0F, 8'hE0},  // R3 I,T untouched
    {SUB,  8'h80, 8'h01, 8'h00, 8'h7F, 8'h38},  // R3 overflow
    {SBC,  8'h00, 8'h00, 8'h01, 8'hFF, 8'h35},  // R3 borrow in
    {CPC,  8'h05, 8'h05, 8'h02, 8'h00, 8'h02},  // R4 Z kept
    {CPC,  8'h05, 8'h05, 8'h00, 8'h00, 8'h00},  // R4 Z not set
    {CP,   8'h03, 8'h05, 8'h00, 8'hFE, 8'h35},  // R3 compare
    {AND_, 8'hF0, 8'h0F, 8'h29, 8'h00, 8'h23},  // R5 V cleared, C H held
    {XOR_, 8'hAA, 8'h55, 8'h00, 8'hFF, 8'h14},  // R5
    {OR_,  8'h00, 8'h00, 8'h04, 8'h00, 8'h02},  // R5
    {INC,  8'h7F, 8'h00, 8'h01, 8'h80, 8'h0D},  // R6
    {DEC,  8'h80, 8'h00, 8'h20, 8'h7F, 8'h38},  // R6
    {DEC,  8'h01, 8'h00, 8'h00, 8'h00, 8'h02},  // R6
    {COM,  8'h5A, 8'h00, 8'h20, 8'hA5, 8'h35},  // R7
    {NEG,  8'h01, 8'h00, 8'h00, 8'hFF, 8'h35},  // R7
    {NEG,  8'h80, 8'h00, 8'h00, 8'h80, 8'h0D},  // R7
    {NEG,  8'h00, 8'h00, 8'h00, 8'h00, 8'h02},  // R7
    {LSL,  8'h81, 8'h00, 8'h00, 8'h02, 8'h19},  // R8 R10
    {ROL,  8'h40, 8'h00, 8'h01, 8'h81, 8'h0C},  // R8
    {ROR,  8'h01, 8'h00, 8'h01, 8'h80, 8'h15},  // R8
    {LSR,  8'h01, 8'h00, 8'h20, 8'h00, 8'h3B},  // R8 H held
    {ASR,  8'h82, 8'h00, 8'h00, 8'hC1, 8'h0C},  // R8
    {SWAP, 8'h3C, 8'h00, 8'hA5, 8'hC3, 8'hA5},  // R9
    {5'd25, 8'h6E, 8'h11, 8'h5A, 8'h6E, 8'h5A}  // R14
  };

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      ADD, ADC:               return "R2";
      SUB, SBC, CP:           return "R3";
      CPC:                    return "R4";
      AND_, OR_, XOR_:        return "R5";
      INC, DEC:               return "R6";
      COM, NEG:               return "R7";
      LSL, LSR, ROL, ROR, ASR: return "R8";
      SWAP:                   return "R9";
      default:                return "R14";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic load_sreg(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      op = v[i] ? BSET : BCLR;
      bit_sel = 3'(i);
      en = 1'b1;
      @(negedge clk);
    end
    en = 1'b0;
  endtask

  task automatic run_op(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y);
    op = o; a = x; b = y; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "status in reset", sreg, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "status after release", sreg, 8'h00);
    bit_sel = 3'd0; br_set = 1'b0; #1;
    check("R13", "cond on clear C", {7'd0, cond}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      logic        ew;
      v = VEC[i];
      load_sreg(v[23:16]);
      op = v[44:40]; a = v[39:32]; b = v[31:24]; en = 1'b1;
      #1;
      ew = (v[44:40] <= SWAP) && (v[44:40] != CP) && (v[44:40] != CPC);
      check(tag_of(v[44:40]), "result", result, v[15:8]);
      check(tag_of(v[44:40]), "wr", {7'd0, wr}, {7'd0, ew});
      @(negedge clk);
      en = 1'b0;
      check(tag_of(v[44:40]), "status", sreg, v[7:0]);
    end

    // R12: disabled op leaves status alone
    load_sreg(8'h35);
    op = ADD; a = 8'hFF; b = 8'h01; en = 1'b0;
    @(negedge clk);
    check("R12", "status with en low", sreg, 8'h35);

    // R11: single-bit set and clear
    load_sreg(8'h00);
    bit_sel = 3'd6; run_op(BSET, 8'h00, 8'h00);
    check("R11", "set bit 6", sreg, 8'h40);
    bit_sel = 3'd6; run_op(BCLR, 8'h00, 8'h00);
    check("R11", "clear bit 6", sreg, 8'h00);
    load_sreg(8'hFF);
    bit_sel = 3'd2; run_op(BCLR, 8'h00, 8'h00);
    check("R11", "clear bit 2", sreg, 8'hFB);

    // R13: signed branch tests on S
    load_sreg(8'h10);
    bit_sel = 3'd4; br_set = 1'b0; #1;
    check("R13", "GE false when S=1", {7'd0, cond}, 8'h00);
    br_set = 1'b1; #1;
    check("R13", "LT true when S=1", {7'd0, cond}, 8'h01);
    load_sreg(8'h0C);
    bit_sel = 3'd4; br_set = 1'b0; #1;
    check("R13", "GE true when N=V=1", {7'd0, cond}, 8'h01);

    // R4: two-byte compares
    load_sreg(8'h00);
    run_op(CP, 8'h34, 8'h34);
    run_op(CPC, 8'h12, 8'h12);
    check("R4", "equal 16-bit Z,C", sreg & 8'h03, 8'h02);
    run_op(CP, 8'h00, 8'hFF);
    run_op(CPC, 8'h12, 8'h12);
    check("R4", "borrow ripple Z,C", sreg & 8'h03, 8'h01);

    // R1: reset in mid-run
    load_sreg(8'hA7);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "status after mid-run reset", sreg, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule